// File: doc/BRIEF.md
# Carry-Chain Magnitude Comparator

This block compares two unsigned operands, A and B, and reports whether A is greater than B. It does not use a behavioural compare. It uses a chain of identical bit cells, and each cell is the carry stage of a ripple adder. Every bit of B is inverted first. Each cell then forms the majority of its A bit, its inverted B bit and the carry from the cell below. The carry out of the top cell is the result.

A control input sets the carry into the least significant cell, which selects the meaning of the result:

- With the control low, the flag means A is strictly greater than B.
- With the control high, the flag means A is greater than or equal to B, because equal operands pass the incoming carry straight through every cell.

The complete carry vector is brought out so that the ripple can be observed. It holds the control input followed by every cell's carry. The block is purely combinational.

The slowest case arises when the operands differ only in bit 0. Then the deciding carry must cross every cell. A difference in a high bit settles the answer logically at once, but the output is only valid once the whole ripple has completed.

Top module: `mag_cmp_chain`

## Requirements
- R1: With `tie_in` = 0, `gt_flag` is 1 exactly when `opa` > `opb` as unsigned integers.
- R2: With `tie_in` = 1, `gt_flag` is 1 exactly when `opa` >= `opb` as unsigned integers.
- R3: When `opa` equals `opb`, `gt_flag` equals `tie_in`.
- R4: Bit 0 of `carry_vec` equals `tie_in`.
- R5: For each k from 1 to WIDTH, bit k of `carry_vec` is 1 exactly when the low k bits of `opa` exceed the low k bits of `opb`, or when those low k bits are equal and `tie_in` is 1.
- R6: `gt_flag` equals bit WIDTH of `carry_vec`.
- R7: For `opa` = 89, the flag is 0 with `opb` = 116, and it is 1 with `opb` = 3 or `opb` = 84, for both values of `tie_in`.
- R8: If the operands differ only in bit 0, with `opa` bit 0 = 1 and `tie_in` = 0, then every bit of `carry_vec` from 1 to WIDTH is 1. The decision has rippled through all cells.
- R9: In any cell whose A bit differs from its inverted B bit, the carry out equals the carry in. In any cell where the two agree, the carry out equals that common value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | Unsigned operand A |
| opb | input | WIDTH | Unsigned operand B |
| tie_in | input | 1 | Carry into the least significant cell; selects strict (0) or non-strict (1) compare |
| gt_flag | output | 1 | Comparison result, the carry out of the top cell |
| carry_vec | output | WIDTH+1 | Bit 0 is `tie_in`; bit k is the carry out of cell k-1 |

## Verification
The bench builds the block with its default WIDTH of 8. At that width, every operand pair for both control values, 131072 vectors in all, fits within one run. This exhaustive sweep covers the ties, the bit-0-only differences and the full-length ripples without having to select them. Each carry vector entry is checked against an integer comparison of the operands' low bits.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

    localparam int CMP_WIDTH_DEFAULT = 8;

    // Inputs seen by one bit cell of the chain.
    typedef struct packed {
        logic a_bit;   // bit of operand A
        logic nb_bit;  // inverted bit of operand B
        logic c_in;    // carry from the cell below
    } cell_in_t;

    // Majority of three: the carry function of a full adder.
    function automatic logic maj3(input cell_in_t v);
        return (v.a_bit & v.nb_bit) | (v.a_bit & v.c_in) | (v.nb_bit & v.c_in);
    endfunction

endpackage

// File: rtl/magcmp_invert.sv
module magcmp_invert #(
    parameter int WIDTH = magcmp_pkg::CMP_WIDTH_DEFAULT
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_inv
        assign dout[i] = ~din[i];
    end
endmodule

// File: rtl/magcmp_cell.sv
module magcmp_cell
    import magcmp_pkg::*;
(
    input  cell_in_t cin_bundle,
    output logic     c_out
);
    assign c_out = maj3(cin_bundle);

    always_comb begin
        // R9: propagate when inputs disagree
        if (cin_bundle.a_bit != cin_bundle.nb_bit) begin
            p_cell_propagate_r9: assert (c_out == cin_bundle.c_in)
                else $error("cell propagate broken");
        end else begin
            // R9: generate/kill when inputs agree
            p_cell_decide_r9: assert (c_out == cin_bundle.a_bit)
                else $error("cell decide broken");
        end
    end
endmodule

// File: rtl/magcmp_chain.sv
module magcmp_chain
    import magcmp_pkg::*;
#(
    parameter int WIDTH = CMP_WIDTH_DEFAULT
) (
    input  logic [WIDTH-1:0] a_bits,
    input  logic [WIDTH-1:0] nb_bits,
    input  logic             c0,
    output logic [WIDTH:0]   carries
);
    assign carries[0] = c0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        cell_in_t bundle;
        assign bundle.a_bit  = a_bits[i];
        assign bundle.nb_bit = nb_bits[i];
        assign bundle.c_in   = carries[i];
        magcmp_cell u_cell (
            .cin_bundle (bundle),
            .c_out      (carries[i+1])
        );
    end
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
    import magcmp_pkg::*;
#(
    parameter int WIDTH = CMP_WIDTH_DEFAULT
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             tie_in,
    output logic             gt_flag,
    output logic [WIDTH:0]   carry_vec
);
    localparam int TOP = WIDTH;

    logic [WIDTH-1:0] opb_n;
    logic [WIDTH:0]   chain_c;

    magcmp_invert #(.WIDTH(WIDTH)) u_inv (
        .din  (opb),
        .dout (opb_n)
    );

    magcmp_chain #(.WIDTH(WIDTH)) u_chain (
        .a_bits  (opa),
        .nb_bits (opb_n),
        .c0      (tie_in),
        .carries (chain_c)
    );

    assign carry_vec = chain_c;
    assign gt_flag   = chain_c[TOP];

    always_comb begin
        if (opa > opb) begin
            p_greater_sets_r1: assert (gt_flag)
                else $error("A>B but flag low");
        end
        if (opa < opb) begin
            p_less_clears_r2: assert (!gt_flag)
                else $error("A<B but flag high");
        end
        if (opa == opb) begin
            p_equal_passes_tie_r3: assert (gt_flag == tie_in)
                else $error("equal operands did not pass control");
        end
        if (opa[0] != opb[0] && opa[WIDTH-1:1] == opb[WIDTH-1:1] && !tie_in) begin
            p_lsb_ripple_r8: assert (gt_flag == opa[0])
                else $error("bit-0 decision lost on ripple");
        end
    end
endmodule

// File: tb/tb_mag_cmp_chain.sv
module tb_mag_cmp_chain;
    localparam int W = 8;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [W-1:0] opa, opb;
    logic         tie_in;
    logic         gt_flag;
    logic [W:0]   carry_vec;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    mag_cmp_chain #(.WIDTH(W)) dut (
        .opa       (opa),
        .opb       (opb),
        .tie_in    (tie_in),
        .gt_flag   (gt_flag),
        .carry_vec (carry_vec)
    );

    function automatic logic ref_carry(int a, int b, int c, int k);
        int m = 1 << k;
        int la = a % m;
        int lb = b % m;
        return (la > lb) || (la == lb && c != 0);
    endfunction

    task automatic apply(input int a, input int b, input int c);
        @(posedge clk);
        #1;
        opa = a[W-1:0];
        opb = b[W-1:0];
        tie_in = c[0];
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: a=%0d b=%0d tie=%0d actual=%b expected=%b",
                     req, opa, opb, tie_in, act, exp);
        end
    endtask

    task automatic chk_vec(input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: a=%0d b=%0d tie=%0d actual=%b expected=%b",
                     req, opa, opb, tie_in, act, exp);
        end
    endtask

    function automatic logic [W:0] ref_vec(int a, int b, int c);
        logic [W:0] v;
        for (int k = 0; k <= W; k++) v[k] = ref_carry(a, b, c, k);
        return v;
    endfunction

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        opa = '0; opb = '0; tie_in = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Quiescent state: zero operands, control low
        apply(0, 0, 0);
        chk("R3 idle", gt_flag, 1'b0);
        chk("R4 idle", carry_vec[0], 1'b0);

        // R7 spot values
        for (int c = 0; c < 2; c++) begin
            apply(89, 116, c); chk("R7 89vs116", gt_flag, 1'b0);
            apply(89, 3, c);   chk("R7 89vs3", gt_flag, 1'b1);
            apply(89, 84, c);  chk("R7 89vs84", gt_flag, 1'b1);
        end

        // R8 bit-0-only difference ripples through all cells
        apply(1, 0, 0);
        chk_vec("R8 full ripple", carry_vec, {{W{1'b1}}, 1'b0});
        apply(255, 254, 0);
        chk("R8 top ripple", gt_flag, 1'b1);
        apply(254, 255, 1);
        chk("R8 lsb loses", gt_flag, 1'b0);

        // R3 ties at extremes
        apply(255, 255, 1); chk("R3 tie max", gt_flag, 1'b1);
        apply(255, 255, 0); chk("R3 tie max", gt_flag, 1'b0);
        apply(0, 0, 1);     chk("R3 tie zero", gt_flag, 1'b1);

        // Exhaustive sweep: R1, R2, R4, R5, R6
        for (int c = 0; c < 2; c++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    apply(a, b, c);
                    if (c == 0) chk("R1 strict", gt_flag, logic'(a > b));
                    else        chk("R2 nonstrict", gt_flag, logic'(a >= b));
                    chk_vec("R4 R5 carry vector", carry_vec, ref_vec(a, b, c));
                    if (a == 0 && b == 0)
                        chk("R6 flag is top carry", gt_flag, carry_vec[W]);
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule